// File: doc/BRIEF.md
# Nozzle Firing Pattern Store and Pulse Gate

This block holds the firing pattern for a row of printhead power lines. A pattern arrives serially on a data pin and a separate clock pin. It is shifted into a staging register and then copied, all at once, into a holding latch by a load strobe. Two active-low pulse strobes then turn the pattern into line enables. The long strobe fires every line whose held bit is set. The short strobe fires every line whose held bit is clear. A host can use one loaded word for a long and a short firing phase without reloading it.

A check-enable pin turns on a nozzle test mode. In that mode every power-line enable is forced off. The set bits of the held word, gated by the long strobe, drive a second set of enables for the test current sources. An active-low hold pin empties both registers and forces every enable off. A clear pin empties only the latch.

Every pin is asynchronous to the system clock. Each pin passes through a synchronizer chain, and its edges are found after the chain. Both enable vectors are registered.

Top module: `nozzle_fire_gate`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_data` into bit 0 of the staging register, and the older bits move one place toward bit WIDTH-1. The first bit of a WIDTH-bit frame therefore ends in bit WIDTH-1, and the last bit ends in bit 0.
- R2: A rising edge of `load_stb` copies the whole staging register into the latch in one step.
- R3: While `load_clr` is high, the latch is held at all zeros, and a `load_stb` edge in that time has no effect.
- R4: While `long_pulse_n` is low and `check_en` is low, `fire_en[i]` is 1 for every i whose latch bit is 1.
- R5: While `short_pulse_n` is low and `check_en` is low, `fire_en[i]` is 1 for every i whose latch bit is 0.
- R6: While `check_en` is high, `fire_en` is all zeros, whatever the pulse strobes do.
- R7: While `check_en` is high, `src_en[i]` is 1 exactly when latch bit i is 1 and `long_pulse_n` is low. `short_pulse_n` has no effect on `src_en`. Outside check mode, `src_en` is all zeros.
- R8: While `hold_n` is low, the staging register and the latch are cleared, and both enable vectors are zero.
- R9: With both pulse strobes high (their idle level), `fire_en` is all zeros.
- R10: A level change on a pulse strobe or on `check_en` reaches the enables on the third rising edge of `clk` after the pin changes. That is the two synchronizer stages plus the output register.
- R11: While the synchronous reset `rst` is high, both registers and both enable vectors are zero, and the strobe pins are taken as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| ser_data | input | 1 | Serial pattern data (asynchronous) |
| ser_clk | input | 1 | Serial shift clock; the rising edge shifts (asynchronous) |
| load_stb | input | 1 | The rising edge copies the staging register into the latch |
| load_clr | input | 1 | High holds the latch at zero |
| long_pulse_n | input | 1 | Low fires the lines whose latch bits are set |
| short_pulse_n | input | 1 | Low fires the lines whose latch bits are clear |
| check_en | input | 1 | High selects nozzle test mode |
| hold_n | input | 1 | Low clears the registers and disables all enables |
| fire_en | output | WIDTH | Power-line enables |
| src_en | output | WIDTH | Test current-source enables |

## Verification
The assertions assume that every pin is stable for several system clocks around each change. In particular, `ser_data` must settle before `ser_clk` rises, so that the synchronized data and clock line up. They also assume that `rst` is high at the first clock edge. The bench changes inputs only on falling clock edges. It holds every serial level and strobe level for at least three clocks, and it sets up data three clocks before each serial clock edge, so the synchronized views of the pins never race.

// File: rtl/nfg_pkg.sv
package nfg_pkg;
  localparam int NFG_WIDTH = 16;
  localparam int NFG_SYNC  = 2;

  typedef struct packed {
    logic sdata;
    logic sclk;
    logic lstb;
    logic lclr;
    logic long_n;
    logic short_n;
    logic chk;
    logic hold_n;
  } nfg_pins_t;

  localparam nfg_pins_t PIN_IDLE = '{sdata: 1'b0, sclk: 1'b0, lstb: 1'b0,
                                     lclr: 1'b0, long_n: 1'b1, short_n: 1'b1,
                                     chk: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/nfg_sync.sv
module nfg_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nfg_store.sv
module nfg_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold_n,
  input  logic         sdata,
  input  logic         sclk,
  input  logic         lstb,
  input  logic         lclr,
  output logic [W-1:0] latch_q
);
  logic [W-1:0] shift_q;
  logic         sclk_d, lstb_d;
  logic         sclk_rise, lstb_rise;

  assign sclk_rise = sclk & ~sclk_d;
  assign lstb_rise = lstb & ~lstb_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      lstb_d <= 1'b0;
    end else begin
      sclk_d <= sclk;
      lstb_d <= lstb;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !hold_n)  shift_q <= '0;
    else if (sclk_rise)  shift_q <= {shift_q[W-2:0], sdata};
  end

  always_ff @(posedge clk) begin
    if (rst || !hold_n || lclr) latch_q <= '0;
    else if (lstb_rise)         latch_q <= shift_q;
  end

  a_r1_shift_in: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && hold_n) |=> (shift_q[0] == $past(sdata)));
  a_r2_copy: assert property (@(posedge clk) disable iff (rst)
    (lstb_rise && hold_n && !lclr) |=> (latch_q == $past(shift_q)));
  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    lclr |=> (latch_q == '0));
  a_r8_hold_regs: assert property (@(posedge clk) disable iff (rst)
    !hold_n |=> (shift_q == '0 && latch_q == '0));
endmodule

// File: rtl/nfg_gate.sv
module nfg_gate #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold_n,
  input  logic [W-1:0] latch_q,
  input  logic         long_n,
  input  logic         short_n,
  input  logic         chk,
  output logic [W-1:0] fire_en,
  output logic [W-1:0] src_en
);
  logic [W-1:0] fire_nx, src_nx;

  always_comb begin
    fire_nx = '0;
    src_nx  = '0;
    if (hold_n) begin
      if (chk) begin
        if (!long_n) src_nx = latch_q;
      end else begin
        if (!long_n)  fire_nx = fire_nx | latch_q;
        if (!short_n) fire_nx = fire_nx | ~latch_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fire_en <= '0;
      src_en  <= '0;
    end else begin
      fire_en <= fire_nx;
      src_en  <= src_nx;
    end
  end

  a_r6_check_blocks: assert property (@(posedge clk) disable iff (rst)
    chk |=> (fire_en == '0));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (long_n && short_n) |=> (fire_en == '0));
  a_r8_hold_outs: assert property (@(posedge clk) disable iff (rst)
    !hold_n |=> (fire_en == '0 && src_en == '0));
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    ((fire_en & src_en) == '0));
  a_r7_no_src_idle: assert property (@(posedge clk) disable iff (rst)
    !chk |=> (src_en == '0));
endmodule

// File: rtl/nozzle_fire_gate.sv
module nozzle_fire_gate
  import nfg_pkg::*;
#(
  parameter int WIDTH = NFG_WIDTH,
  parameter int SYNC_STAGES = NFG_SYNC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_data,
  input  logic             ser_clk,
  input  logic             load_stb,
  input  logic             load_clr,
  input  logic             long_pulse_n,
  input  logic             short_pulse_n,
  input  logic             check_en,
  input  logic             hold_n,
  output logic [WIDTH-1:0] fire_en,
  output logic [WIDTH-1:0] src_en
);
  localparam int PW = $bits(nfg_pins_t);

  nfg_pins_t         pin_raw, pin_s;
  logic [PW-1:0]     pin_q;
  logic [WIDTH-1:0]  latch_q;

  assign pin_raw = '{sdata: ser_data, sclk: ser_clk, lstb: load_stb,
                     lclr: load_clr, long_n: long_pulse_n,
                     short_n: short_pulse_n, chk: check_en, hold_n: hold_n};

  nfg_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_raw),
    .q   (pin_q)
  );

  assign pin_s = pin_q;

  nfg_store #(.W(WIDTH)) u_store (
    .clk     (clk),
    .rst     (rst),
    .hold_n  (pin_s.hold_n),
    .sdata   (pin_s.sdata),
    .sclk    (pin_s.sclk),
    .lstb    (pin_s.lstb),
    .lclr    (pin_s.lclr),
    .latch_q (latch_q)
  );

  nfg_gate #(.W(WIDTH)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .hold_n  (pin_s.hold_n),
    .latch_q (latch_q),
    .long_n  (pin_s.long_n),
    .short_n (pin_s.short_n),
    .chk     (pin_s.chk),
    .fire_en (fire_en),
    .src_en  (src_en)
  );
endmodule

// File: tb/nozzle_fire_gate_test.sv
module nozzle_fire_gate_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_data = 1'b0, ser_clk = 1'b0, load_stb = 1'b0, load_clr = 1'b0;
  logic long_pulse_n = 1'b1, short_pulse_n = 1'b1, check_en = 1'b0, hold_n = 1'b1;
  logic [W-1:0] fire_en, src_en;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nozzle_fire_gate uut (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk),
    .load_stb(load_stb), .load_clr(load_clr), .long_pulse_n(long_pulse_n),
    .short_pulse_n(short_pulse_n), .check_en(check_en), .hold_n(hold_n),
    .fire_en(fire_en), .src_en(src_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) begin
      ser_data = w[i];
      tick(3);
      ser_clk = 1'b1;
      tick(3);
      ser_clk = 1'b0;
      tick(1);
    end
  endtask

  task automatic strobe();
    load_stb = 1'b1;
    tick(3);
    load_stb = 1'b0;
    tick(4);
  endtask

  task automatic set_pulses(input logic ln, input logic sn, input logic ck);
    long_pulse_n = ln;
    short_pulse_n = sn;
    check_en = ck;
    tick(4);
  endtask

  initial begin
    tick(3);
    check("R11 fire", fire_en, '0);
    check("R11 src", src_en, '0);
    rst = 1'b0;
    tick(2);

    // sweep of patterns: R1 R2 R4 R5 R6 R7 R9
    for (int k = 0; k < 10; k++) begin
      logic [W-1:0] pat;
      pat = W'(k * 16'h1357) ^ (16'h8000 >> k);
      send_word(pat);
      strobe();
      set_pulses(1'b1, 1'b1, 1'b0);
      check("R9 idle", fire_en, '0);
      set_pulses(1'b0, 1'b1, 1'b0);
      check("R1/R2 R4 long", fire_en, pat);
      set_pulses(1'b1, 1'b0, 1'b0);
      check("R5 short", fire_en, ~pat);
      set_pulses(1'b0, 1'b0, 1'b0);
      check("R4 R5 both", fire_en, '1);
      set_pulses(1'b0, 1'b0, 1'b1);
      check("R6 check fire", fire_en, '0);
      check("R7 check src", src_en, pat);
      set_pulses(1'b1, 1'b0, 1'b1);
      check("R7 short no src", src_en, '0);
      set_pulses(1'b1, 1'b1, 1'b0);
      check("R7 src off", src_en, '0);
    end

    // R10 latency
    send_word(16'h00F1);
    strobe();
    long_pulse_n = 1'b0;
    tick(1);
    tick(1);
    check("R10 before", fire_en, '0);
    tick(1);
    check("R10 third edge", fire_en, 16'h00F1);
    long_pulse_n = 1'b1;
    tick(4);

    // R3 clear, with strobe ignored while clear is high
    send_word(16'hBEEF);
    load_clr = 1'b1;
    tick(3);
    strobe();
    set_pulses(1'b0, 1'b1, 1'b0);
    check("R3 clear held", fire_en, '0);
    load_clr = 1'b0;
    tick(4);
    check("R3 after clear", fire_en, '0);
    strobe();
    check("R3 reload", fire_en, 16'hBEEF);
    set_pulses(1'b1, 1'b1, 1'b0);

    // R8 hold clears both registers
    set_pulses(1'b0, 1'b1, 1'b1);
    hold_n = 1'b0;
    tick(4);
    check("R8 src", src_en, '0);
    set_pulses(1'b0, 1'b0, 1'b0);
    check("R8 fire", fire_en, '0);
    hold_n = 1'b1;
    set_pulses(1'b1, 1'b1, 1'b0);
    strobe();
    set_pulses(1'b1, 1'b0, 1'b0);
    check("R8 shift empty", fire_en, '1);
    set_pulses(1'b0, 1'b1, 1'b0);
    check("R8 latch empty", fire_en, '0);
    set_pulses(1'b1, 1'b1, 1'b0);

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule